// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block arbitrates five interrupt sources for a small 8-bit processor core. Two of them are asynchronous, active-low external pins. Two are overflow flags from on-chip counters. The fifth is a serial-port flag. Each source has its own enable bit and a one-bit priority, and a global enable gates all of them. Of the eligible sources, the block presents one to the core as a registered request that carries a vector address and the level of the request.

The core answers with an acknowledge when it starts servicing the request, and with a return strobe when a handler finishes. The block keeps one in-service flag per level. These flags control nesting: a high-level request can interrupt a low-level handler, and nothing can interrupt a high-level handler. Each external pin can be set to level-sensitive or falling-edge mode. In edge mode a captured edge is held until that source is acknowledged.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, irq_req, in_svc_hi and in_svc_lo are all 0.
- R2: A high-level eligible source always wins over low-level ones. Inside one level, the lowest polling index wins: ext0=0, cnt0=1, ext1=2, cnt1=3, serial=4. src_en, src_hi and the source bits are indexed by that number: bit 1 of cnt_ovf goes with index 3, and bit 1 of ext_req_n goes with index 2.
- R3: irq_vector equals 8 × index + 3 of the presented source. irq_level is 1 for a high-level request and 0 for a low-level one.
- R4: A source is presented only when both its src_en bit and gbl_en are 1. A masked source stays pending and is presented once it is unmasked.
- R5: An ack seen while irq_req is 1 sets the in-service flag of the presented level. irq_req is 0 in the cycle after that ack.
- R6: While in_svc_hi is 1, no request is presented. While only in_svc_lo is 1, only high-level sources are presented.
- R7: A reti pulse clears in_svc_hi if it is set, and clears in_svc_lo otherwise.
- R8: External pins pass through a two-stage synchronizer. In level mode, a pin driven low is seen as irq_req=1 after the third rising clock edge, and a pin driven high again withdraws the request after the same delay.
- R9: In edge mode (ext_edge bit = 1), a falling edge is latched and stays pending after the pin returns high. The latch is cleared when that source is acknowledged.
- R10: Counter and serial flags are active high and are seen at irq_req after the next rising edge.
- R11: An ack while irq_req is 0 changes neither in-service flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req_n | input | 2 | Asynchronous external request pins, active low |
| ext_edge | input | 2 | Per-pin mode: 1 = falling edge, 0 = low level |
| cnt_ovf | input | 2 | Counter overflow flags, active high |
| ser_flag | input | 1 | Serial-port flag, active high |
| gbl_en | input | 1 | Global interrupt enable |
| src_en | input | 5 | Per-source enable, by polling index |
| src_hi | input | 5 | Per-source priority, 1 = high level |
| ack | input | 1 | Core accepts the presented request |
| reti | input | 1 | Core leaves the current handler |
| irq_req | output | 1 | Registered request to the core |
| irq_vector | output | 8 | Vector address of the presented source |
| irq_level | output | 1 | Level of the presented request |
| in_svc_hi | output | 1 | High-level handler in service |
| in_svc_lo | output | 1 | Low-level handler in service |

## Verification
The hardest state to reach is a fully nested one. A low-level handler is in service, a high-level handler has preempted it, and both a high-level and a low-level source keep requesting. Only in that state can the test show that the return strobe clears the high flag first and that same-level preemption is refused. A directed sequence acknowledges a low request, raises a high source, acknowledges it, and adds another high source. Random traffic on the internal flags, with random acks and returns, then reaches the same state many more times under varied masks.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int NSRC    = 5;
  localparam int IDX_W   = $clog2(NSRC);
  localparam int NEXT    = 2;
  localparam int IDX_SER = NSRC - 1;

  // polling position of external pin e: pins and counters interleave
  function automatic int ext_pos(input int e);
    return 2 * e;
  endfunction

  function automatic int cnt_pos(input int c);
    return 2 * c + 1;
  endfunction
endpackage

// File: rtl/irq_pin_cond.sv
module irq_pin_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic edge_md,
  input  logic clr,
  output logic req
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   latch_q;
  logic                   fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall = prev_q & ~sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst)          latch_q <= 1'b0;
    else if (!edge_md) latch_q <= 1'b0;
    else if (fall)    latch_q <= 1'b1;
    else if (clr)     latch_q <= 1'b0;
  end

  assign req = edge_md ? latch_q : ~sync_q[SYNC_STAGES-1];

  AST_EDGE_HELD: assert property (@(posedge clk) disable iff (rst)
    (latch_q && edge_md && !clr) |=> latch_q); // R9
  AST_EDGE_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (latch_q && edge_md && clr && !fall) |=> !latch_q); // R9
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  pend,
  input  logic [N-1:0]  en,
  input  logic [N-1:0]  prio,
  input  logic          gen,
  input  logic          act_hi,
  input  logic          act_lo,
  output logic          valid,
  output logic          hi,
  output logic [IW-1:0] idx
);
  logic [N-1:0] hi_m;
  logic [N-1:0] lo_m;
  logic [N-1:0] sel;

  always_comb begin
    hi_m  = pend & en & prio  & {N{gen & ~act_hi}};
    lo_m  = pend & en & ~prio & {N{gen & ~act_hi & ~act_lo}};
    sel   = (|hi_m) ? hi_m : lo_m;
    valid = |sel;
    hi    = |hi_m;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (sel[i]) idx = IW'(i);
    end
  end

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !gen |-> !valid); // R4
  AST_HI_FIRST: assert property (@(posedge clk) disable iff (rst)
    ((|(pend & en & prio)) && gen && !act_hi) |-> (valid && hi)); // R2
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic take_hi,
  input  logic reti,
  output logic act_hi,
  output logic act_lo
);
  always_ff @(posedge clk) begin
    if (rst) begin
      act_hi <= 1'b0;
      act_lo <= 1'b0;
    end else begin
      if (reti) begin
        if (act_hi) act_hi <= 1'b0;
        else        act_lo <= 1'b0;
      end
      if (take) begin
        if (take_hi) act_hi <= 1'b1;
        else         act_lo <= 1'b1;
      end
    end
  end

  AST_TAKE_SETS: assert property (@(posedge clk) disable iff (rst)
    take |=> ($past(take_hi) ? act_hi : act_lo)); // R5
  AST_RETI_ORDER: assert property (@(posedge clk) disable iff (rst)
    (reti && !take && act_hi) |=> (!act_hi && $stable(act_lo))); // R7
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int VEC_W       = 8,
  parameter int VEC_STRIDE  = 8,
  parameter int VEC_BASE    = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [irq_nest_pkg::NEXT-1:0]  ext_req_n,
  input  logic [irq_nest_pkg::NEXT-1:0]  ext_edge,
  input  logic [irq_nest_pkg::NEXT-1:0]  cnt_ovf,
  input  logic                            ser_flag,
  input  logic                            gbl_en,
  input  logic [irq_nest_pkg::NSRC-1:0]  src_en,
  input  logic [irq_nest_pkg::NSRC-1:0]  src_hi,
  input  logic                            ack,
  input  logic                            reti,
  output logic                            irq_req,
  output logic [VEC_W-1:0]                irq_vector,
  output logic                            irq_level,
  output logic                            in_svc_hi,
  output logic                            in_svc_lo
);
  import irq_nest_pkg::*;

  logic [NSRC-1:0]  pend;
  logic             take;
  logic             pick_valid;
  logic             pick_hi;
  logic [IDX_W-1:0] pick_idx;
  logic [IDX_W-1:0] src_q;
  logic             req_q;
  logic             lvl_q;
  logic [VEC_W-1:0] vec_q;

  assign take = ack & req_q;

  for (genvar e = 0; e < NEXT; e++) begin : g_ext
    logic ext_clr;
    logic ext_pend;
    assign ext_clr = take && (src_q == IDX_W'(ext_pos(e)));
    irq_pin_cond #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
      .clk     (clk),
      .rst     (rst),
      .pin_n   (ext_req_n[e]),
      .edge_md (ext_edge[e]),
      .clr     (ext_clr),
      .req     (ext_pend)
    );
    assign pend[ext_pos(e)] = ext_pend;
    assign pend[cnt_pos(e)] = cnt_ovf[e];
  end
  assign pend[IDX_SER] = ser_flag;

  irq_pick #(.N(NSRC), .IW(IDX_W)) u_pick (
    .clk    (clk),
    .rst    (rst),
    .pend   (pend),
    .en     (src_en),
    .prio   (src_hi),
    .gen    (gbl_en),
    .act_hi (in_svc_hi),
    .act_lo (in_svc_lo),
    .valid  (pick_valid),
    .hi     (pick_hi),
    .idx    (pick_idx)
  );

  irq_level_track u_lvl (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .take_hi (lvl_q),
    .reti    (reti),
    .act_hi  (in_svc_hi),
    .act_lo  (in_svc_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      src_q <= '0;
      lvl_q <= 1'b0;
      vec_q <= '0;
    end else begin
      req_q <= pick_valid & ~take;
      src_q <= pick_idx;
      lvl_q <= pick_hi;
      vec_q <= VEC_W'(int'(pick_idx) * VEC_STRIDE + VEC_BASE);
    end
  end

  assign irq_req    = req_q;
  assign irq_vector = vec_q;
  assign irq_level  = lvl_q;

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_req) |=> !irq_req); // R5
  AST_HI_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    in_svc_hi |-> !irq_req); // R6
  AST_LO_ONLY_HI: assert property (@(posedge clk) disable iff (rst)
    (in_svc_lo && irq_req) |-> irq_level); // R6
  AST_IDLE_ACK: assert property (@(posedge clk) disable iff (rst)
    (ack && !irq_req && !reti) |=> ($stable(in_svc_hi) && $stable(in_svc_lo))); // R11
endmodule

// File: tb/irq_nest_ctrl_test.sv
module irq_nest_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ext_req_n = 2'b11;
  logic [1:0] ext_edge = 2'b00;
  logic [1:0] cnt_ovf = 2'b00;
  logic       ser_flag = 1'b0;
  logic       gbl_en = 1'b0;
  logic [4:0] src_en = 5'b0;
  logic [4:0] src_hi = 5'b0;
  logic       ack = 1'b0;
  logic       reti = 1'b0;
  logic       irq_req;
  logic [7:0] irq_vector;
  logic       irq_level;
  logic       in_svc_hi;
  logic       in_svc_lo;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  irq_nest_ctrl uut (
    .clk(clk), .rst(rst), .ext_req_n(ext_req_n), .ext_edge(ext_edge),
    .cnt_ovf(cnt_ovf), .ser_flag(ser_flag), .gbl_en(gbl_en),
    .src_en(src_en), .src_hi(src_hi), .ack(ack), .reti(reti),
    .irq_req(irq_req), .irq_vector(irq_vector), .irq_level(irq_level),
    .in_svc_hi(in_svc_hi), .in_svc_lo(in_svc_lo)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(3);
    rst = 1'b0;
  endtask

  // reference arbiter: returns winning polling index or -1
  function automatic int pick_ref(input logic [4:0] pend, input logic [4:0] en,
                                  input logic [4:0] pr, input logic g,
                                  input logic h, input logic l);
    if (!g || h) return -1;
    for (int i = 0; i < 5; i++) if (pend[i] && en[i] && pr[i]) return i;
    if (l) return -1;
    for (int i = 0; i < 5; i++) if (pend[i] && en[i] && !pr[i]) return i;
    return -1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic mhi, mlo, obs_req, obs_lvl;
    void'($urandom(32'h1D5));
    do_reset();
    chk("R1", "irq_req after reset", irq_req, 0);
    chk("R1", "in_svc_hi after reset", in_svc_hi, 0);
    chk("R1", "in_svc_lo after reset", in_svc_lo, 0);

    // random traffic on internal flags
    mhi = 0; mlo = 0; obs_req = 0; obs_lvl = 0;
    for (int it = 0; it < 3000; it++) begin
      int r, e;
      logic doack, doreti, idle_ack;
      logic [4:0] pend;
      r = int'($urandom % 5);
      doack    = obs_req && (r == 0);
      idle_ack = !obs_req && (r == 2);
      doreti   = !doack && !idle_ack && (r == 1) && (mhi || mlo);
      cnt_ovf  = 2'($urandom);
      ser_flag = 1'($urandom);
      src_en   = ($urandom % 4 == 0) ? 5'($urandom) : 5'b11111;
      src_hi   = 5'($urandom);
      gbl_en   = ($urandom % 8) != 0;
      ack      = doack || idle_ack;
      reti     = doreti;
      pend     = {ser_flag, cnt_ovf[1], 1'b0, cnt_ovf[0], 1'b0};
      e = doack ? -1 : pick_ref(pend, src_en, src_hi, gbl_en, mhi, mlo);
      step();
      ack = 0; reti = 0;
      chk("R2", "random irq_req", irq_req, (e >= 0) ? 1 : 0);
      if (e >= 0) begin
        chk("R3", "random irq_vector", irq_vector, 8 * e + 3);
        chk("R2", "random irq_level", irq_level, src_hi[e]);
      end
      if (doack) begin
        if (obs_lvl) mhi = 1; else mlo = 1;
      end
      if (doreti) begin
        if (mhi) mhi = 0; else mlo = 0;
      end
      chk("R5", "random in_svc_hi", in_svc_hi, mhi);
      chk("R11", "random in_svc_lo", in_svc_lo, mlo);
      obs_req = irq_req;
      obs_lvl = irq_level;
    end

    // directed: level-mode pin latency and withdrawal
    cnt_ovf = 0; ser_flag = 0; gbl_en = 0;
    do_reset();
    src_en = 5'b11111; src_hi = 5'b0; gbl_en = 1; ext_edge = 2'b00;
    ext_req_n[0] = 1'b0;
    step(2);
    chk("R8", "level pin before third edge", irq_req, 0);
    step();
    chk("R8", "level pin after third edge", irq_req, 1);
    chk("R3", "ext0 vector", irq_vector, 3);
    ext_req_n[0] = 1'b1;
    step(2);
    chk("R8", "release before third edge", irq_req, 1);
    step();
    chk("R9", "level release withdraws", irq_req, 0);

    // directed: edge mode latch
    ext_edge[1] = 1'b1;
    ext_req_n[1] = 1'b0;
    step();
    ext_req_n[1] = 1'b1;
    step(6);
    chk("R9", "edge latched after pin high", irq_req, 1);
    chk("R3", "ext1 vector", irq_vector, 19);
    chk("R3", "ext1 low level", irq_level, 0);
    ack = 1; step(); ack = 0;
    chk("R5", "req drops after ack", irq_req, 0);
    chk("R5", "low flag set by ack", in_svc_lo, 1);
    reti = 1; step(); reti = 0;
    chk("R7", "reti clears low", in_svc_lo, 0);
    step(3);
    chk("R9", "edge latch cleared by ack", irq_req, 0);
    ext_edge = 2'b00;

    // directed: gating
    src_en = 5'b10111; cnt_ovf[1] = 1'b1;
    step();
    chk("R4", "source enable off", irq_req, 0);
    src_en = 5'b11111; gbl_en = 0;
    step();
    chk("R4", "global enable off", irq_req, 0);
    gbl_en = 1;
    step();
    chk("R10", "counter flag one edge", irq_req, 1);
    chk("R4", "pending taken after unmask", irq_vector, 27);

    // directed: nesting
    ack = 1; step(); ack = 0;
    chk("R5", "low handler active", in_svc_lo, 1);
    chk("R5", "req low after ack", irq_req, 0);
    ser_flag = 1; src_hi[4] = 1'b1;
    step();
    chk("R6", "high preempts low", irq_req, 1);
    chk("R6", "preempt vector", irq_vector, 35);
    chk("R3", "preempt level", irq_level, 1);
    ack = 1; step(); ack = 0;
    chk("R5", "high handler active", in_svc_hi, 1);
    cnt_ovf[0] = 1'b1; src_hi[1] = 1'b1;
    step(2);
    chk("R6", "high not preempted", irq_req, 0);
    reti = 1; step(); reti = 0;
    chk("R7", "reti clears high first", in_svc_hi, 0);
    chk("R7", "low still in service", in_svc_lo, 1);
    step();
    chk("R2", "high tie lowest index", irq_vector, 11);
    chk("R6", "high shown under low", irq_req, 1);
    cnt_ovf = 0; ser_flag = 0;
    step();
    reti = 1; step(); reti = 0;
    chk("R7", "second reti clears low", in_svc_lo, 0);

    // directed: ties and idle ack
    src_hi = 5'b0; cnt_ovf = 2'b11; ser_flag = 1;
    step();
    chk("R2", "low tie lowest index", irq_vector, 11);
    src_hi = 5'b10000;
    step();
    chk("R2", "high beats lower index", irq_vector, 35);
    cnt_ovf = 0; ser_flag = 0;
    step();
    ack = 1; step(); ack = 0;
    chk("R11", "idle ack hi flag", in_svc_hi, 0);
    chk("R11", "idle ack lo flag", in_svc_lo, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule